// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block controls one port of up to eight general-purpose pins behind a byte-wide register bus. Software works through a full register window. That window holds the pin direction, the driven output value and the synchronized input value. It also provides atomic set, clear and toggle strobes for direction and for output, and a write-one-to-clear flag register. A second, compact window reaches the same storage at low offsets. It holds only four registers: direction, output, input and flags.

The pin side drives an output enable and an output value for each pin. The pin levels pass through a two-flop synchronizer before software can read them. Hardware flag events arrive on a per-pin input and set the matching flag bit. Bus reads are combinational from the selected offset. Bus writes take effect at the next rising clock edge. Only one window is selected in any cycle.

Top module: `gpio_port`

Full-window offsets: 0 direction, 1 direction-set, 2 direction-clear, 3 direction-toggle, 4 output, 5 output-set, 6 output-clear, 7 output-toggle, 8 input, 9 flags. Compact-window offsets: 0 direction, 1 output, 2 input, 3 flags.

## Requirements
- R1: After reset the direction, output and flag registers are all 0, so `pin_oe` and `pin_out` are 0 and every pin is an input.
- R2: A write to offset 0 of the full window loads the direction register. A write to the direction-set, direction-clear or direction-toggle offset (1, 2, 3) changes only the bits written as 1, and the change appears on `pin_oe` after the next clock edge.
- R3: The output register has its own set, clear and toggle offsets (5, 6, 7) beside the plain write at offset 4. They act on `pin_out` in the same bit-selective way.
- R4: A read of any set, clear or toggle offset returns the current value of its base register (direction or output), not zero.
- R5: The compact window (offsets 0, 1, 2, 3) reads and writes the same direction, output, input and flag storage as the full window.
- R6: A write to the compact input offset (2) toggles `pin_out` for each bit written as 1. A write to the full input offset (8) changes nothing.
- R7: The output register drives only `pin_out`. Writing it leaves `pin_oe` unchanged, and `pin_out` follows it even for pins whose direction bit is 0.
- R8: The flag register is write-one-to-clear from either window. A bit written as 0 keeps its value.
- R9: A bit of `flag_evt` high at a clock edge sets that flag. If software clears the same bit in the same cycle, the set wins.
- R10: A level on `pin_in` appears in the input register after the second rising clock edge. The synchronizer resets to 0.
- R11: A full-window offset above 9 reads as 0, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_full_sel | input | 1 | Selects the full register window this cycle |
| bus_fast_sel | input | 1 | Selects the compact register window this cycle |
| bus_addr | input | 4 | Register offset within the selected window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected offset, combinational |
| pin_in | input | 8 | Raw pin levels |
| flag_evt | input | 8 | Per-pin hardware flag set events |
| pin_oe | output | 8 | Per-pin output enable (direction register) |
| pin_out | output | 8 | Per-pin driven value (output register) |

## Verification
Register writes reach `pin_oe`, `pin_out` and the flag register one edge after the write cycle, so the bench checks them in the cycle after the write. A `flag_evt` pulse likewise shows in a read one cycle later. A change on `pin_in` stays invisible for one cycle and appears in the second cycle after the change, and the bench checks both sides of that boundary. The internal reset is released two edges after `rst_n` rises, so the bench waits before its first checks. The monitor samples `bus_rdata` and the pin outputs at the falling edge of the same cycle in which the driver queued the expected item.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  // Full window offsets
  localparam logic [3:0] FW_DIR     = 4'd0;
  localparam logic [3:0] FW_DIR_SET = 4'd1;
  localparam logic [3:0] FW_DIR_CLR = 4'd2;
  localparam logic [3:0] FW_DIR_TGL = 4'd3;
  localparam logic [3:0] FW_OUT     = 4'd4;
  localparam logic [3:0] FW_OUT_SET = 4'd5;
  localparam logic [3:0] FW_OUT_CLR = 4'd6;
  localparam logic [3:0] FW_OUT_TGL = 4'd7;
  localparam logic [3:0] FW_IN      = 4'd8;
  localparam logic [3:0] FW_FLG     = 4'd9;

  // Compact window offsets
  localparam logic [3:0] CW_DIR = 4'd0;
  localparam logic [3:0] CW_OUT = 4'd1;
  localparam logic [3:0] CW_IN  = 4'd2;
  localparam logic [3:0] CW_FLG = 4'd3;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic tgl;
  } bitop_t;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_DIR  = 3'd1,
    RD_OUT  = 3'd2,
    RD_IN   = 3'd3,
    RD_FLG  = 3'd4
  } rd_src_e;

endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_decode.sv
`timescale 1ns/1ps
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          full_sel,
  input  logic          fast_sel,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  output bitop_t        dir_op,
  output bitop_t        out_op,
  output logic          flg_clr,
  output rd_src_e       rd_src
);
  logic [3:0] off;
  assign off = 4'(addr);

  always_comb begin
    dir_op  = '0;
    out_op  = '0;
    flg_clr = 1'b0;
    rd_src  = RD_NONE;
    if (full_sel) begin
      case (off)
        FW_DIR:     begin rd_src = RD_DIR; dir_op.load = wr; end
        FW_DIR_SET: begin rd_src = RD_DIR; dir_op.set  = wr; end
        FW_DIR_CLR: begin rd_src = RD_DIR; dir_op.clr  = wr; end
        FW_DIR_TGL: begin rd_src = RD_DIR; dir_op.tgl  = wr; end
        FW_OUT:     begin rd_src = RD_OUT; out_op.load = wr; end
        FW_OUT_SET: begin rd_src = RD_OUT; out_op.set  = wr; end
        FW_OUT_CLR: begin rd_src = RD_OUT; out_op.clr  = wr; end
        FW_OUT_TGL: begin rd_src = RD_OUT; out_op.tgl  = wr; end
        FW_IN:      rd_src = RD_IN;   // write ignored here
        FW_FLG:     begin rd_src = RD_FLG; flg_clr = wr; end
        default:    rd_src = RD_NONE;
      endcase
    end else if (fast_sel) begin
      case (off)
        CW_DIR:  begin rd_src = RD_DIR; dir_op.load = wr; end
        CW_OUT:  begin rd_src = RD_OUT; out_op.load = wr; end
        CW_IN:   begin rd_src = RD_IN;  out_op.tgl  = wr; end
        CW_FLG:  begin rd_src = RD_FLG; flg_clr     = wr; end
        default: rd_src = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bitop_reg.sv
`timescale 1ns/1ps
module gpio_bitop_reg
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bitop_t       op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;
  logic         en;

  assign en = op.load | op.set | op.clr | op.tgl;

  always_comb begin
    q_nxt = q_r;
    if (op.load)     q_nxt = wdata;
    else if (op.set) q_nxt = q_r | wdata;
    else if (op.clr) q_nxt = q_r & ~wdata;
    else if (op.tgl) q_nxt = q_r ^ wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_flag_reg.sv
`timescale 1ns/1ps
module gpio_flag_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt, clr_bits;
  logic         en;

  assign clr_bits = clr_wr ? clr_mask : '0;
  assign en       = clr_wr | (|evt);

  always_comb begin
    q_nxt = (q_r & ~clr_bits) | evt;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_full_sel,
  input  logic              bus_fast_sel,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] flag_evt,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_out
);
  localparam int unsigned RST_STAGES = 2;

  logic              rst_n_int;
  bitop_t            dir_op, out_op;
  logic              flg_clr;
  rd_src_e           rd_src;
  logic [N_PINS-1:0] dir_q, out_q, in_q, flag_q;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  gpio_bus_decode #(.AW(AW)) u_dec (
    .full_sel(bus_full_sel), .fast_sel(bus_fast_sel), .addr(bus_addr),
    .wr(bus_wr), .dir_op(dir_op), .out_op(out_op), .flg_clr(flg_clr),
    .rd_src(rd_src)
  );

  gpio_bitop_reg #(.W(N_PINS)) u_dir (
    .clk(clk), .rst_n(rst_n_int), .op(dir_op), .wdata(bus_wdata), .q(dir_q)
  );

  gpio_bitop_reg #(.W(N_PINS)) u_out (
    .clk(clk), .rst_n(rst_n_int), .op(out_op), .wdata(bus_wdata), .q(out_q)
  );

  gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d(pin_in), .q(in_q)
  );

  gpio_flag_reg #(.W(N_PINS)) u_flg (
    .clk(clk), .rst_n(rst_n_int), .clr_wr(flg_clr), .clr_mask(bus_wdata),
    .evt(flag_evt), .q(flag_q)
  );

  always_comb begin
    case (rd_src)
      RD_DIR:  bus_rdata = dir_q;
      RD_OUT:  bus_rdata = out_q;
      RD_IN:   bus_rdata = in_q;
      RD_FLG:  bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              full_sel,
  input logic              fast_sel,
  input logic [AW-1:0]     addr,
  input logic              wr,
  input logic [N_PINS-1:0] rdata,
  input logic [N_PINS-1:0] flag_evt,
  input logic [N_PINS-1:0] pin_oe,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] flags
);
  logic [3:0] off;
  logic dir_touch, out_touch, flg_touch, full_in_wr;

  assign off        = 4'(addr);
  assign dir_touch  = wr && ((full_sel && off <= FW_DIR_TGL) ||
                             (!full_sel && fast_sel && off == CW_DIR));
  assign out_touch  = wr && ((full_sel && off >= FW_OUT && off <= FW_OUT_TGL) ||
                             (!full_sel && fast_sel && (off == CW_OUT || off == CW_IN)));
  assign flg_touch  = wr && ((full_sel && off == FW_FLG) ||
                             (!full_sel && fast_sel && off == CW_FLG));
  assign full_in_wr = wr && full_sel && off == FW_IN;

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_touch |=> $stable(pin_oe));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_touch |=> $stable(pin_out));

  p_alias_rd_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_sel && off == FW_DIR_CLR) |-> rdata == pin_oe);

  p_alias_rd_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_sel && off == FW_OUT_TGL) |-> rdata == pin_out);

  p_fast_dir_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_sel && fast_sel && off == CW_DIR) |-> rdata == pin_oe);

  p_full_in_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_in_wr |=> ($stable(pin_out) && $stable(pin_oe)));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_evt == '0 && !flg_touch) |=> $stable(flags));

  p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_evt != '0) |=> ((flags & $past(flag_evt)) == $past(flag_evt)));
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n_int), .full_sel(bus_full_sel), .fast_sel(bus_fast_sel),
  .addr(bus_addr), .wr(bus_wr), .rdata(bus_rdata), .flag_evt(flag_evt),
  .pin_oe(pin_oe), .pin_out(pin_out), .flags(flag_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam int K_RD = 0;
  localparam int K_OE = 1;
  localparam int K_OUT = 2;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       full_sel, fast_sel, wr;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, pin_in, evt, oe, pout;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;
  item_t      sb_q[$];

  always #4 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_full_sel(full_sel), .bus_fast_sel(fast_sel),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pin_in(pin_in), .flag_evt(evt), .pin_oe(oe), .pin_out(pout)
  );

  // Driver: one bus cycle, driven just after the rising edge
  task automatic step(input logic fs, input logic ls, input logic [3:0] a,
                      input logic w, input logic [7:0] d, input logic [7:0] ev,
                      input logic [7:0] pin);
    @(posedge clk);
    #1;
    full_sel = fs; fast_sel = ls; addr = a; wr = w; wdata = d; evt = ev; pin_in = pin;
  endtask

  task automatic idle(input logic [7:0] pin);
    step(1'b0, 1'b0, 4'd0, 1'b0, 8'h00, 8'h00, pin);
  endtask

  task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge of the cycle the item was queued
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb_q.pop_front();
      got = (it.kind == K_RD) ? rdata : (it.kind == K_OE) ? oe : pout;
      n_tests++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] pv;
    pv = 8'h00;
    rst_n = 1'b0; full_sel = 0; fast_sel = 0; addr = 0; wr = 0; wdata = 0;
    evt = 0; pin_in = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle(pv);

    // R1 reset state
    idle(pv);                              expect_item(K_OE, 8'h00, "R1 pin_oe");
                                           expect_item(K_OUT, 8'h00, "R1 pin_out");
    step(1, 0, 4'd0, 0, 0, 0, pv);         expect_item(K_RD, 8'h00, "R1 dir read");
    step(1, 0, 4'd9, 0, 0, 0, pv);         expect_item(K_RD, 8'h00, "R1 flag read");
    step(1, 0, 4'd8, 0, 0, 0, pv);         expect_item(K_RD, 8'h00, "R10 sync reset");

    // R2 direction and its aliases
    step(1, 0, 4'd0, 1, 8'hF0, 0, pv); idle(pv); expect_item(K_OE, 8'hF0, "R2 dir load");
    step(1, 0, 4'd1, 1, 8'h03, 0, pv); idle(pv); expect_item(K_OE, 8'hF3, "R2 dir set");
    step(1, 0, 4'd2, 1, 8'h30, 0, pv); idle(pv); expect_item(K_OE, 8'hC3, "R2 dir clr");
    step(1, 0, 4'd3, 1, 8'h0F, 0, pv); idle(pv); expect_item(K_OE, 8'hCC, "R2 dir tgl");

    // R4 alias reads return the base register
    step(1, 0, 4'd1, 0, 0, 0, pv); expect_item(K_RD, 8'hCC, "R4 dir-set read");
    step(1, 0, 4'd2, 0, 0, 0, pv); expect_item(K_RD, 8'hCC, "R4 dir-clr read");
    step(1, 0, 4'd3, 0, 0, 0, pv); expect_item(K_RD, 8'hCC, "R4 dir-tgl read");

    // R3 output and its aliases, R7 direction untouched
    step(1, 0, 4'd4, 1, 8'h11, 0, pv); idle(pv); expect_item(K_OUT, 8'h11, "R3 out load");
    step(1, 0, 4'd5, 1, 8'h06, 0, pv); idle(pv); expect_item(K_OUT, 8'h17, "R3 out set");
    step(1, 0, 4'd6, 1, 8'h10, 0, pv); idle(pv); expect_item(K_OUT, 8'h07, "R3 out clr");
    step(1, 0, 4'd7, 1, 8'hFF, 0, pv); idle(pv); expect_item(K_OUT, 8'hF8, "R3 out tgl");
                                                 expect_item(K_OE, 8'hCC, "R7 oe unchanged");
    step(1, 0, 4'd6, 0, 0, 0, pv); expect_item(K_RD, 8'hF8, "R4 out-clr read");
    step(1, 0, 4'd5, 0, 0, 0, pv); expect_item(K_RD, 8'hF8, "R4 out-set read");

    // R7 output drives an input-configured pin's value only
    step(1, 0, 4'd0, 1, 8'h00, 0, pv); idle(pv);
    step(1, 0, 4'd4, 1, 8'hA5, 0, pv); idle(pv);
    expect_item(K_OUT, 8'hA5, "R7 out with dir 0");
    expect_item(K_OE, 8'h00, "R7 oe stays 0");

    // R5 compact window on shared storage
    step(0, 1, 4'd0, 1, 8'h55, 0, pv); idle(pv); expect_item(K_OE, 8'h55, "R5 fast dir write");
    step(1, 0, 4'd0, 0, 0, 0, pv); expect_item(K_RD, 8'h55, "R5 full dir read");
    step(0, 1, 4'd1, 1, 8'h0F, 0, pv); idle(pv); expect_item(K_OUT, 8'h0F, "R5 fast out write");
    step(0, 1, 4'd1, 0, 0, 0, pv); expect_item(K_RD, 8'h0F, "R5 fast out read");

    // R6 input writes
    step(1, 0, 4'd8, 1, 8'hFF, 0, pv); idle(pv);
    expect_item(K_OUT, 8'h0F, "R6 full in write ignored");
    expect_item(K_OE, 8'h55, "R6 full in write oe");
    step(0, 1, 4'd2, 1, 8'h81, 0, pv); idle(pv);
    expect_item(K_OUT, 8'h8E, "R6 fast in write toggles");

    // R8 / R9 flags
    step(0, 0, 4'd0, 0, 0, 8'h0F, pv);
    step(1, 0, 4'd9, 0, 0, 0, pv); expect_item(K_RD, 8'h0F, "R9 event sets flags");
    step(1, 0, 4'd9, 1, 8'h00, 0, pv);
    step(1, 0, 4'd9, 0, 0, 0, pv); expect_item(K_RD, 8'h0F, "R8 zero write keeps flags");
    step(0, 1, 4'd3, 1, 8'h05, 0, pv);
    step(0, 1, 4'd3, 0, 0, 0, pv); expect_item(K_RD, 8'h0A, "R8 fast w1c");
    step(1, 0, 4'd9, 1, 8'h02, 8'h02, pv);
    step(1, 0, 4'd9, 0, 0, 0, pv); expect_item(K_RD, 8'h0A, "R9 set beats clear");
    step(1, 0, 4'd9, 1, 8'h0A, 0, pv);
    step(1, 0, 4'd9, 0, 0, 0, pv); expect_item(K_RD, 8'h00, "R8 full w1c");

    // R11 unmapped offset
    step(1, 0, 4'd13, 1, 8'hFF, 0, pv); expect_item(K_RD, 8'h00, "R11 unmapped read");
    idle(pv); expect_item(K_OE, 8'h55, "R11 oe unchanged");
              expect_item(K_OUT, 8'h8E, "R11 out unchanged");

    // R10 synchronizer latency
    pv = 8'h3C;
    idle(pv);
    step(1, 0, 4'd8, 0, 0, 0, pv); expect_item(K_RD, 8'h00, "R10 one edge: old value");
    step(1, 0, 4'd8, 0, 0, 0, pv); expect_item(K_RD, 8'h3C, "R10 two edges: new value");
    pv = 8'h5A;
    idle(pv);
    step(0, 1, 4'd2, 0, 0, 0, pv); expect_item(K_RD, 8'h3C, "R10 fast in old value");
    step(0, 1, 4'd2, 0, 0, 0, pv); expect_item(K_RD, 8'h5A, "R10 fast in new value");

    idle(pv);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule